// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps up to 22 recently used logical-to-physical page mappings and translates each processor access in a single clock. The tag of a mapping is the logical page number (address bits 31:12, 4 KB pages) together with the 3-bit function code of the access. Any mapping may sit in any slot. Every lookup is compared against all valid slots at once, and the answer comes back registered one cycle later.

A hit returns the physical address, which is the stored physical page number joined with the untouched page offset. It also returns the slot's cache-inhibit flag and the request's function code. A write that hits a write-protected slot is reported as a protection fault and yields no address. A lookup that matches no slot reports a miss. This tells the requester to abort the access, start a hardware table walk and retry once the walker has written the new mapping through the fill port.

Slots can be invalidated all at once with a flush.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, so any lookup answers with miss set and hit, fault, physical address and cache-inhibit all zero.
- R2: A lookup presented in cycle t is answered in cycle t+1 with rsp_valid_o high. It is a hit when a valid slot holds the same logical page (addr bits 31:12) and the same function code. A hit drives rsp_paddr_o = {slot page number, addr bits 11:0} and rsp_ci_o = the slot's cache-inhibit bit. At most one slot ever matches.
- R3: rsp_fc_o equals the function code of the request on every response, whatever the outcome.
- R4: A write (req_write_i=1) that matches a slot whose write-protect bit is set gives rsp_fault_o=1, rsp_hit_o=0 and rsp_paddr_o=0. Reads of that slot still hit.
- R5: A lookup that matches no valid slot gives rsp_miss_o=1 and rsp_paddr_o=0. Every response raises exactly one of hit, miss and fault.
- R6: A lookup in the same cycle as a fill of a tag not yet held answers miss. The same lookup retried one cycle later hits with the filled mapping.
- R7: A fill of a new tag goes to the lowest-numbered invalid slot. When there is none, it goes to the slot named by a replacement pointer. The pointer starts at 0 and steps by one, modulo 22, on every accepted fill.
- R8: A flush invalidates every slot in one cycle. A lookup in the flush cycle answers miss, and a fill in the flush cycle is discarded.
- R9: A fill whose tag is already held overwrites that slot's page number and status bits instead of creating a second copy.
- R10: All 22 distinct mappings can be held and hit at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all slots |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 32 | Logical address of the access |
| req_fc_i | input | 3 | Function code of the access |
| req_write_i | input | 1 | Access is a write |
| fill_valid_i | input | 1 | Write a mapping from the table walker |
| fill_lpn_i | input | 20 | Logical page number of the mapping |
| fill_fc_i | input | 3 | Function code of the mapping |
| fill_ppn_i | input | 20 | Physical page number of the mapping |
| fill_wp_i | input | 1 | Write-protect bit of the mapping |
| fill_ci_i | input | 1 | Cache-inhibit bit of the mapping |
| rsp_valid_o | output | 1 | Response for the previous cycle's lookup |
| rsp_hit_o | output | 1 | Translation found, access may proceed |
| rsp_miss_o | output | 1 | No translation: abort and walk the tables |
| rsp_fault_o | output | 1 | Write to a write-protected page |
| rsp_paddr_o | output | 32 | Physical address on a hit |
| rsp_ci_o | output | 1 | Cache-inhibit of the hit page |
| rsp_fc_o | output | 3 | Function code passed through |

## Verification
A lookup and a fill can land in the same cycle, and so can a lookup and a flush. The bench drives a lookup together with a fill of the very tag being looked up, and expects a miss in that cycle and a hit on the retry one cycle later. It also drives a lookup of a held tag in the flush cycle and expects a miss. Finally it drives a fill together with a flush and expects the later lookup of that tag to miss. Every other check uses one function per cycle, so each outcome can be traced to a single cause.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int ADDR_W = 32;
  parameter int OFS_W  = 12;
  parameter int FC_W   = 3;
  parameter int PN_W   = ADDR_W - OFS_W;

  typedef struct packed {
    logic [PN_W-1:0] lpn;
    logic [FC_W-1:0] fc;
    logic [PN_W-1:0] ppn;
    logic            wp;
    logic            ci;
  } slot_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 22
) (
  input  xlat_pkg::slot_t [ENTRIES-1:0] slots_i,
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [xlat_pkg::PN_W-1:0]     lpn_i,
  input  logic [xlat_pkg::FC_W-1:0]     fc_i,
  output logic [ENTRIES-1:0]            hit_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (slots_i[g].lpn == lpn_i) && (slots_i[g].fc == fc_i);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 22,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   rr_i,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = rr_i;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 22
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        req_valid_i,
  input  logic [xlat_pkg::ADDR_W-1:0] req_addr_i,
  input  logic [xlat_pkg::FC_W-1:0]   req_fc_i,
  input  logic                        req_write_i,
  input  logic                        fill_valid_i,
  input  logic [xlat_pkg::PN_W-1:0]   fill_lpn_i,
  input  logic [xlat_pkg::FC_W-1:0]   fill_fc_i,
  input  logic [xlat_pkg::PN_W-1:0]   fill_ppn_i,
  input  logic                        fill_wp_i,
  input  logic                        fill_ci_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic                        rsp_miss_o,
  output logic                        rsp_fault_o,
  output logic [xlat_pkg::ADDR_W-1:0] rsp_paddr_o,
  output logic                        rsp_ci_o,
  output logic [xlat_pkg::FC_W-1:0]   rsp_fc_o
);
  import xlat_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  slot_t [ENTRIES-1:0] slots_q;
  logic  [ENTRIES-1:0] valid_q;
  logic  [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] look_hit, fill_hit;
  logic [IDX_W-1:0]   victim_idx, fill_idx, held_idx;
  slot_t              sel;
  logic               look_any, fill_en;
  logic               hit_d, miss_d, fault_d;

  xlat_match #(.ENTRIES(ENTRIES)) u_look (
    .slots_i(slots_q), .valid_i(valid_q),
    .lpn_i(req_addr_i[ADDR_W-1:OFS_W]), .fc_i(req_fc_i), .hit_o(look_hit));

  xlat_match #(.ENTRIES(ENTRIES)) u_fill (
    .slots_i(slots_q), .valid_i(valid_q),
    .lpn_i(fill_lpn_i), .fc_i(fill_fc_i), .hit_o(fill_hit));

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i(valid_q), .rr_i(rr_q), .idx_o(victim_idx));

  // one-hot mux of the matching slot and index of a held fill tag
  always_comb begin
    sel      = '0;
    held_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_hit[i]) sel = sel | slots_q[i];
      if (fill_hit[i]) held_idx = held_idx | IDX_W'(i);
    end
  end

  assign fill_en  = fill_valid_i && !flush_i;
  assign fill_idx = (|fill_hit) ? held_idx : victim_idx;
  assign look_any = (|look_hit) && !flush_i;
  assign fault_d  = req_valid_i && look_any && req_write_i && sel.wp;
  assign hit_d    = req_valid_i && look_any && !fault_d;
  assign miss_d   = req_valid_i && !look_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      slots_q <= '0;
      rr_q    <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      slots_q[fill_idx] <= '{lpn: fill_lpn_i, fc: fill_fc_i, ppn: fill_ppn_i,
                             wp: fill_wp_i, ci: fill_ci_i};
      rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_ci_o    <= 1'b0;
      rsp_fc_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= hit_d;
      rsp_miss_o  <= miss_d;
      rsp_fault_o <= fault_d;
      rsp_paddr_o <= hit_d ? {sel.ppn, req_addr_i[OFS_W-1:0]} : '0;
      rsp_ci_o    <= hit_d && sel.ci;
      rsp_fc_o    <= req_fc_i;
    end
  end

  // R2: tags never duplicate
  a_r2_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_hit));
  // R5: one outcome per response
  a_r5_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1);
  // R4: a fault never carries an address
  a_r4_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (!rsp_hit_o && rsp_paddr_o == '0));
  // R6: new tag filled alongside its lookup answers miss
  a_r6_fill_race_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fill_en && !(|fill_hit) && fill_lpn_i == req_addr_i[ADDR_W-1:OFS_W]
     && fill_fc_i == req_fc_i) |=> rsp_miss_o);
  // R8: flush empties all slots
  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
  // R7: replacement pointer stays in range
  a_r7_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q < IDX_W'(ENTRIES));
  // R9: refill of a held tag keeps the valid count
  a_r9_refill_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && (|fill_hit)) |=> $countones(valid_q) == $past($countones(valid_q)));
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int N = 22;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush = 0, req_valid = 0, req_write = 0, fill_valid = 0, fill_wp = 0, fill_ci = 0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_fc = '0, fill_fc = '0;
  logic [19:0] fill_lpn = '0, fill_ppn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ci;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fc;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_cache u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_fc_i(req_fc), .req_write_i(req_write),
    .fill_valid_i(fill_valid), .fill_lpn_i(fill_lpn), .fill_fc_i(fill_fc),
    .fill_ppn_i(fill_ppn), .fill_wp_i(fill_wp), .fill_ci_i(fill_ci),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr), .rsp_ci_o(rsp_ci), .rsp_fc_o(rsp_fc));

  function automatic logic [19:0] lpn_of(int i); return 20'(i * 37 + 5); endfunction
  function automatic logic [2:0]  fc_of(int i);  return 3'(i % 8); endfunction
  function automatic logic [19:0] ppn_of(int i); return 20'(i * 101 + 3); endfunction
  function automatic logic        wp_of(int i);  return (i % 3) == 0; endfunction
  function automatic logic        ci_of(int i);  return (i % 2) == 1; endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // set fill inputs; caller advances the clock
  task automatic set_fill(input logic [19:0] lpn, input logic [2:0] fc, input logic [19:0] ppn,
                          input logic wp, input logic ci);
    fill_valid = 1; fill_lpn = lpn; fill_fc = fc; fill_ppn = ppn; fill_wp = wp; fill_ci = ci;
  endtask

  task automatic fill(input logic [19:0] lpn, input logic [2:0] fc, input logic [19:0] ppn,
                      input logic wp, input logic ci);
    set_fill(lpn, fc, ppn, wp, ci);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic set_req(input logic [19:0] lpn, input logic [2:0] fc, input logic wr, input logic [11:0] ofs);
    req_valid = 1; req_addr = {lpn, ofs}; req_fc = fc; req_write = wr;
  endtask

  // full lookup: drive, one edge, sample at negedge
  task automatic look(input logic [19:0] lpn, input logic [2:0] fc, input logic wr, input logic [11:0] ofs);
    set_req(lpn, fc, wr, ofs);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_hit(input string req, input logic [19:0] ppn, input logic [11:0] ofs,
                            input logic ci, input logic [2:0] fc);
    chk(rsp_valid && rsp_hit && !rsp_miss && !rsp_fault, req, {rsp_hit, rsp_miss, rsp_fault}, 3'b100);
    chk(rsp_paddr == {ppn, ofs} && rsp_ci == ci, req, {rsp_ci, rsp_paddr}, {ci, ppn, ofs});
    chk(rsp_fc == fc, {req, " R3 fc"}, rsp_fc, fc);
  endtask

  task automatic expect_miss(input string req);
    chk(rsp_valid && rsp_miss && !rsp_hit && !rsp_fault && rsp_paddr == 0, req,
        {rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, {3'b010, 32'h0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rsp_valid && !rsp_hit && rsp_paddr == 0, "R1 idle outputs", {rsp_valid, rsp_hit}, 0);
    rst_ni = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      look(lpn_of(i), fc_of(i), 0, 12'(i));
      expect_miss("R1 empty lookup");
    end

    // R10, R7: fill all slots (pointer returns to 0)
    for (int i = 0; i < N; i++) fill(lpn_of(i), fc_of(i), ppn_of(i), wp_of(i), ci_of(i));
    for (int i = 0; i < N; i++) begin
      look(lpn_of(i), fc_of(i), 0, 12'(i * 181));
      expect_hit("R10 R2 read hit", ppn_of(i), 12'(i * 181), ci_of(i), fc_of(i));
    end
    // R2: function code is part of the tag
    for (int i = 0; i < N; i++) begin
      look(lpn_of(i), fc_of(i) ^ 3'b100, 0, 12'h0);
      expect_miss("R2 fc mismatch");
      chk(rsp_fc == (fc_of(i) ^ 3'b100), "R3 fc on miss", rsp_fc, fc_of(i) ^ 3'b100);
    end
    // R4: writes against write protect
    for (int i = 0; i < N; i++) begin
      look(lpn_of(i), fc_of(i), 1, 12'hABC);
      if (wp_of(i))
        chk(rsp_fault && !rsp_hit && !rsp_miss && rsp_paddr == 0, "R4 protected write",
            {rsp_fault, rsp_hit, rsp_paddr}, {2'b10, 32'h0});
      else
        expect_hit("R4 unprotected write", ppn_of(i), 12'hABC, ci_of(i), fc_of(i));
    end

    // R9: refill held tag 5 with new data (pointer 0 -> 1)
    fill(lpn_of(5), fc_of(5), 20'hFEED1, 1'b0, 1'b1);
    look(lpn_of(5), fc_of(5), 1, 12'h123);
    expect_hit("R9 refill updates", 20'hFEED1, 12'h123, 1'b1, fc_of(5));
    look(lpn_of(0), fc_of(0), 0, 12'h0);
    expect_hit("R9 no eviction on refill", ppn_of(0), 12'h0, ci_of(0), fc_of(0));

    // R7: full cache, victim is pointer=1 -> tag 1 evicted
    fill(20'hAAAAA, 3'd7, 20'h11111, 1'b0, 1'b0);
    look(lpn_of(1), fc_of(1), 0, 12'h0);
    expect_miss("R7 round-robin victim evicted");
    look(20'hAAAAA, 3'd7, 0, 12'h055);
    expect_hit("R7 new tag present", 20'h11111, 12'h055, 1'b0, 3'd7);
    look(lpn_of(2), fc_of(2), 0, 12'h0);
    expect_hit("R7 neighbour kept", ppn_of(2), 12'h0, ci_of(2), fc_of(2));

    // R6: fill and lookup of same new tag in one cycle (victim tag 2)
    set_fill(20'h55555, 3'd2, 20'h22222, 1'b0, 1'b1);
    set_req(20'h55555, 3'd2, 0, 12'h777);
    @(negedge clk);
    fill_valid = 0;
    expect_miss("R6 same-cycle fill miss");
    look(20'h55555, 3'd2, 0, 12'h777);
    expect_hit("R6 retry hits", 20'h22222, 12'h777, 1'b1, 3'd2);
    look(lpn_of(2), fc_of(2), 0, 12'h0);
    expect_miss("R7 second victim evicted");

    // R8: lookup in flush cycle misses, then all miss
    set_req(lpn_of(3), fc_of(3), 0, 12'h0);
    flush = 1;
    @(negedge clk);
    flush = 0; req_valid = 0;
    expect_miss("R8 lookup during flush");
    for (int i = 0; i < N; i++) begin
      look(lpn_of(i), fc_of(i), 0, 12'h0);
      expect_miss("R8 empty after flush");
    end
    // R8: fill during flush is dropped
    set_fill(20'h0BEEF, 3'd1, 20'h33333, 1'b0, 1'b0);
    flush = 1;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    look(20'h0BEEF, 3'd1, 0, 12'h0);
    expect_miss("R8 fill discarded by flush");
    // refill after flush works
    fill(20'h0BEEF, 3'd1, 20'h33333, 1'b0, 1'b0);
    look(20'h0BEEF, 3'd1, 0, 12'hFFF);
    expect_hit("R2 fill after flush", 20'h33333, 12'hFFF, 1'b0, 3'd1);

    @(negedge clk);
    chk(!rsp_valid, "R2 no response without request", rsp_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule